// File: doc/BRIEF.md
# Time-Multiplexed Three-Tap FIR Engine

This block is a one-dimensional three-tap FIR filter built around a single multiply-accumulator that steps through the taps one at a time. The block takes one new 8-bit unsigned sample every three clock cycles. An addressable shift register holds the three most recent samples. A small register file holds three signed 4-bit coefficients, which are loaded through a simple write port.

A modulo-three phase counter drives the read address of both the sample window and the coefficient store. A comparator on that counter marks the first tap and the last tap. Both marks are delayed by one cycle to match the registered product. On the first tap the accumulator loads the product, which drops the previous frame's sum. On the other two taps it adds the product to the sum.

When the last tap has been added, a capture register latches the sum. A down-sampler then keeps one result per frame and presents it on a signed output, together with a one-cycle valid strobe. Several of these engines can each process one row of a two-dimensional kernel, and a wider datapath can add their outputs. That combining stage is not part of this block.

Top module: `tdm_fir3_mac`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `valid_o` is 0 and `result_o` is 0. The coefficients and the stored samples also reset to zero, so every result is 0 until coefficients are written.
- R2: The phase counter counts 0, 1, 2, 0 and so on from reset. `sample_i` is taken only at the clock edge that ends phase 2, which is every third edge after reset release (edges 3, 6, 9 and so on). Values present at any other edge have no effect.
- R3: Each result equals c0·x[n] + c1·x[n−1] + c2·x[n−2]. Here x[n] is the newest sample, and c0, c1 and c2 are the coefficients at addresses 0, 1 and 2. Samples are unsigned, coefficients are 4-bit two's complement, and `result_o` is a 15-bit two's-complement value.
- R4: The accumulator restarts on tap 0 of every frame, so no sum carries over from one frame to the next. After three zero samples the result is exactly 0.
- R5: `valid_o` is a one-cycle pulse that repeats every three cycles. Its first pulse follows the sixth clock edge after reset release. `result_o` changes only together with a pulse.
- R6: The result whose newest sample was taken at edge E appears with `valid_o` right after edge E+6. This is the third pulse after the pulse at which the sample was driven.
- R7: When `coef_we_i` is high at an edge, `coef_data_i` is written to coefficient `coef_addr_i`. A write to address 3, or with `coef_we_i` low, changes no coefficient.
- R8: The full input range never overflows. All samples at 255 with all coefficients at −8 gives −6120. All samples at 255 with all coefficients at 7 gives 5355.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 8 | Unsigned input sample, taken at the end of phase 2 |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 2 | Coefficient address (0..2 valid) |
| coef_data_i | input | 4 | Signed coefficient to write |
| result_o | output | 15 | Signed filtered result |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
A table of coefficient sets is streamed with three samples followed by zeros. Each set is checked at four outputs: the full three-sample sum, the shifted-out sums that involve only c1 and c2 or only c2, and the all-zero frame. Together these outputs pin down the tap order, expose a wrong newest-sample index, and catch an accumulator that fails to restart. Signed/unsigned mix-ups are caught by sets with negative and asymmetric coefficients, and by the two extreme-magnitude sets. Separate directed runs check the reset values and the pulse timing. They also toggle the sample only during the non-load phases, and issue coefficient writes that must be ignored, so that a misaligned sample load or a stray write shows up at the result.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
  typedef struct packed {
    logic first;
    logic last;
  } tap_flags_t;
endpackage

// File: rtl/fir_tap_seq.sv
module fir_tap_seq
  import tdm_fir_pkg::*;
#(
  parameter int TAPS   = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              shift_o,
  output tap_flags_t        flags_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TAPS - 1);

  logic [ADDR_W-1:0] cnt_q;
  tap_flags_t        flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST_ADDR) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // comparator marks, delayed one stage to line up with the product register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else begin
      flags_q.first <= (cnt_q == '0);
      flags_q.last  <= (cnt_q == LAST_ADDR);
    end
  end

  assign addr_o  = cnt_q;
  assign shift_o = (cnt_q == LAST_ADDR);
  assign flags_o = flags_q;
endmodule

// File: rtl/fir_sample_window.sv
module fir_sample_window #(
  parameter int SAMPLE_W = 8,
  parameter int TAPS     = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic [SAMPLE_W-1:0]      sample_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic [SAMPLE_W-1:0]      tap_o,
  output logic [TAPS*SAMPLE_W-1:0] win_o
);
  logic [SAMPLE_W-1:0] win_q [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) win_q[k] <= '0;
        else if (shift_i) win_q[k] <= sample_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) win_q[k] <= '0;
        else if (shift_i) win_q[k] <= win_q[k-1];
      end
    end
    assign win_o[k*SAMPLE_W +: SAMPLE_W] = win_q[k];
  end

  always_comb begin
    tap_o = '0;
    for (int k = 0; k < TAPS; k++)
      if (addr_i == ADDR_W'(k)) tap_o = win_q[k];
  end
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int COEF_W = 4,
  parameter int TAPS   = 3,
  parameter int ADDR_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic signed [COEF_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic signed [COEF_W-1:0] coef_o
);
  logic signed [COEF_W-1:0] mem_q [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[k] <= '0;
      else if (we_i && waddr_i == ADDR_W'(k)) mem_q[k] <= wdata_i;
    end
  end

  always_comb begin
    coef_o = '0;
    for (int k = 0; k < TAPS; k++)
      if (raddr_i == ADDR_W'(k)) coef_o = mem_q[k];
  end
endmodule

// File: rtl/fir_mac_core.sv
module fir_mac_core
  import tdm_fir_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 4,
  parameter int PROD_W   = 13,
  parameter int ACC_W    = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SAMPLE_W-1:0]      sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  input  tap_flags_t               flags_i,
  output logic signed [PROD_W-1:0] prod_o,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     done_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod_d, prod_q;
  logic signed [ACC_W-1:0]  acc_q, prod_wide;
  logic                     done_q;

  // unsigned sample, signed coefficient: widen both to the product width
  assign a_ext     = PROD_W'(sample_i);
  assign b_ext     = PROD_W'(coef_i);
  assign prod_d    = a_ext * b_ext;
  assign prod_wide = ACC_W'(prod_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else prod_q <= prod_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= flags_i.first ? prod_wide : acc_q + prod_wide;
      done_q <= flags_i.last;
    end
  end

  assign prod_o = prod_q;
  assign acc_o  = acc_q;
  assign done_o = done_q;
endmodule

// File: rtl/fir_capture_decim.sv
module fir_capture_decim #(
  parameter int ACC_W = 15
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    done_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [ACC_W-1:0] result_o,
  output logic                    valid_o
);
  logic signed [ACC_W-1:0] cap_q, out_q;
  logic                    cap_vld_q, out_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= '0;
      cap_vld_q <= 1'b0;
    end else begin
      cap_vld_q <= done_i;
      if (done_i) cap_q <= acc_i;
    end
  end

  // keep one result per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= cap_vld_q;
      if (cap_vld_q) out_q <= cap_q;
    end
  end

  assign result_o = out_q;
  assign valid_o  = out_vld_q;
endmodule

// File: rtl/tdm_fir3_mac.sv
module tdm_fir3_mac
  import tdm_fir_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 4,
  parameter int TAPS     = 3,
  localparam int ADDR_W  = (TAPS > 2) ? $clog2(TAPS) : 1,
  localparam int PROD_W  = SAMPLE_W + 1 + COEF_W,
  localparam int ACC_W   = PROD_W + $clog2(TAPS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                coef_we_i,
  input  logic [ADDR_W-1:0]   coef_addr_i,
  input  logic [COEF_W-1:0]   coef_data_i,
  output logic [ACC_W-1:0]    result_o,
  output logic                valid_o
);
  logic [ADDR_W-1:0]        tap_addr;
  logic                     shift_en;
  tap_flags_t               flags;
  logic [SAMPLE_W-1:0]      tap_sample;
  logic [TAPS*SAMPLE_W-1:0] win_flat;
  logic signed [COEF_W-1:0] tap_coef;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic                     acc_done;
  logic signed [ACC_W-1:0]  result_s;

  fir_tap_seq #(.TAPS(TAPS), .ADDR_W(ADDR_W)) i_seq (
    .clk_i, .rst_ni, .addr_o(tap_addr), .shift_o(shift_en), .flags_o(flags)
  );

  fir_sample_window #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .ADDR_W(ADDR_W)) i_win (
    .clk_i, .rst_ni, .shift_i(shift_en), .sample_i, .addr_i(tap_addr),
    .tap_o(tap_sample), .win_o(win_flat)
  );

  fir_coef_store #(.COEF_W(COEF_W), .TAPS(TAPS), .ADDR_W(ADDR_W)) i_coef (
    .clk_i, .rst_ni, .we_i(coef_we_i), .waddr_i(coef_addr_i),
    .wdata_i(coef_data_i), .raddr_i(tap_addr), .coef_o(tap_coef)
  );

  fir_mac_core #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .ACC_W(ACC_W)) i_mac (
    .clk_i, .rst_ni, .sample_i(tap_sample), .coef_i(tap_coef), .flags_i(flags),
    .prod_o(prod), .acc_o(acc), .done_o(acc_done)
  );

  fir_capture_decim #(.ACC_W(ACC_W)) i_cap (
    .clk_i, .rst_ni, .done_i(acc_done), .acc_i(acc), .result_o(result_s), .valid_o
  );

  assign result_o = result_s;
endmodule

// File: rtl/tdm_fir3_mac_chk.sv
module tdm_fir3_mac_chk #(
  parameter int SAMPLE_W = 8,
  parameter int TAPS     = 3,
  parameter int ADDR_W   = 2,
  parameter int PROD_W   = 13,
  parameter int ACC_W    = 15
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_o,
  input logic [ACC_W-1:0]         result_o,
  input logic [ADDR_W-1:0]        tap_addr,
  input logic                     shift_en,
  input logic [SAMPLE_W-1:0]      sample_i,
  input logic [TAPS*SAMPLE_W-1:0] win_flat,
  input logic                     first_flag,
  input logic [PROD_W-1:0]        prod,
  input logic [ACC_W-1:0]         acc
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hff) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tap_addr) < TAPS);

  // R2
  window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en |=> $stable(win_flat));

  // R2
  window_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> win_flat[SAMPLE_W-1:0] == $past(sample_i));

  // R4
  acc_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_flag |=> acc == ACC_W'($signed($past(prod))));

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  valid_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> 32'(gap_q) == TAPS - 1);

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

bind tdm_fir3_mac tdm_fir3_mac_chk #(
  .SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .ADDR_W(ADDR_W), .PROD_W(PROD_W), .ACC_W(ACC_W)
) i_chk (
  .clk_i, .rst_ni, .valid_o, .result_o, .tap_addr, .shift_en, .sample_i,
  .win_flat, .first_flag(flags.first), .prod, .acc
);

// File: tb/test_tdm_fir3_mac.sv
module test_tdm_fir3_mac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sample_i = '0;
  logic        coef_we_i = 1'b0;
  logic [1:0]  coef_addr_i = '0;
  logic [3:0]  coef_data_i = '0;
  logic [14:0] result_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  tdm_fir3_mac i_tdm_fir3_mac (
    .clk_i, .rst_ni, .sample_i, .coef_we_i, .coef_addr_i, .coef_data_i,
    .result_o, .valid_o
  );

  // c0, c1, c2, x0, x1, x2
  localparam int NVEC = 6;
  localparam int VEC [NVEC][6] = '{
    '{ 1,  2,  1,  10,  20,  30},
    '{-1,  0,  1, 100,  50,  25},
    '{ 7, -8,  3, 255,   0, 255},
    '{-8, -8, -8, 255, 255, 255},
    '{ 7,  7,  7, 255, 255, 255},
    '{ 0,  5, -3,   1,   2,   3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_coef(input int addr, input int val, input logic we);
    @(negedge clk_i);
    coef_we_i   = we;
    coef_addr_i = 2'(addr);
    coef_data_i = 4'(val);
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!valid_o);
  endtask

  function automatic int res();
    return int'($signed(result_o));
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R5: watchdog expired, actual no finish expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s [9];
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", int'(valid_o), 0);
    check("R1 result in reset", res(), 0);
    rst_ni = 1'b1;
    // R5: first pulse right after edge 6
    repeat (5) @(negedge clk_i);
    check("R5 no pulse after edge 5", int'(valid_o), 0);
    @(negedge clk_i);
    check("R5 pulse after edge 6", int'(valid_o), 1);
    check("R1 zero result with reset coefficients", res(), 0);
    @(negedge clk_i);
    check("R5 pulse lasts one cycle", int'(valid_o), 0);
    repeat (2) @(negedge clk_i);
    check("R5 pulse repeats after 3 cycles", int'(valid_o), 1);

    // R3 R4 R6 R8: vector table
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < 3; k++) write_coef(k, VEC[v][k], 1'b1);
      for (int p = 0; p < 9; p++) s[p] = (p < 3) ? VEC[v][3+p] : 0;
      for (int p = 0; p < 9; p++) begin
        wait_pulse();
        if (p >= 5)
          check((p == 8) ? "R4 frame restart" : "R3 R6 R8 filter sum", res(),
                VEC[v][0]*s[p-3] + VEC[v][1]*s[p-4] + VEC[v][2]*s[p-5]);
        sample_i = 8'(s[p]);
      end
    end

    // R7: writes that must be ignored, then coefficients 1,1,1
    for (int k = 0; k < 3; k++) write_coef(k, 1, 1'b1);
    write_coef(3, -8, 1'b1);
    write_coef(0, 7, 1'b0);
    for (int p = 0; p < 6; p++) begin
      wait_pulse();
      sample_i = (p == 0) ? 8'd10 : 8'd0;
      if (p >= 3) check("R7 ignored coefficient writes", res(), 10);
    end

    // R2: sample changes off the load edge are ignored
    for (int p = 0; p < 6; p++) begin
      wait_pulse();
      sample_i = 8'd200;
      @(negedge clk_i);
      sample_i = 8'd0;
      if (p >= 3) check("R2 off-phase sample ignored", res(), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule